// File: doc/BRIEF.md
# Double-Buffered Peripheral DMA Channel

This block is one channel of a DMA engine that moves bytes between system memory and an on-chip peripheral, in either direction. Two descriptor slots each hold a byte count and a base address. Software can fill the idle slot while the other slot's buffer is moving, so a stream of buffers runs back to back without gaps.

A four-state controller tracks how many buffers are loaded. The states are idle, stall (running with nothing loaded), on (one loaded) and next (two loaded). Software loads a slot by writing its count and then its base address. The channel reports two causes, derived from its state. The first means "stalled, nothing left to move". The second means "a slot is free for the next buffer". A third cause is a sticky error flag raised by a failed memory access. Each cause can be masked on its own to drive a single interrupt line.

On the memory side the channel issues single-beat byte accesses and holds each request until it is acknowledged. On the peripheral side it waits for a request, then pulses an acknowledge as it hands over or takes a byte.

Top module: `pdma_chan`

## Requirements
- R1: After reset, the status state field (bits [5:4] of offset 0x0C) reads 0 (idle), `irq` is low and `mem_req` is low.
- R2: Register offsets are decoded as follows, and written values read back one cycle after `reg_rd`:
  - control at 0x00, with bit 0 stall-interrupt enable, bit 1 free-slot-interrupt enable, bit 2 direction (1 = peripheral to memory), bit 3 error-interrupt enable and bit 4 run;
  - cause at 0x04;
  - port select at 0x08 (4 bits);
  - status at 0x0C;
  - remaining count at 0x14;
  - slot-0 count and base at 0x20 and 0x24;
  - slot-1 count and base at 0x30 and 0x34.
- R3: Setting run moves idle to stall (state 1). While run is clear, a base write stores the address but starts no transfer and makes no memory access.
- R4: While running, a base write to either slot loads that slot: stall goes to on (state 2), and on goes to next (state 3). A base write while in next is ignored, and the base register keeps its old value.
- R5: In memory-to-peripheral mode, bytes are read from consecutive addresses starting at the base. Each byte is presented on `per_wdata` with a one-cycle `per_ack` pulse, and the remaining count (0x14) drops by one per byte. `mem_req` stays high, with a stable address, until `mem_ack`.
- R6: In peripheral-to-memory mode (control bit 2 = 1), each byte taken from `per_rdata` with a `per_ack` pulse is written to memory at consecutive addresses from the base.
- R7: When the active buffer completes in next, the channel moves to on and starts the other loaded buffer, whose bytes follow in order. The free-slot cause (bit 1 of 0x04) is then active.
- R8: When the active buffer completes in on, the channel moves to stall, the stall cause (bit 0 of 0x04) is active and the remaining count reads 0.
- R9: `irq` is high only when the stall cause, the free-slot cause or the error flag is set together with its enable bit. It follows them with one register stage.
- R10: Clearing run does not abort the buffer in progress. The channel finishes it and enters idle only from stall.
- R11: A memory error response sets the sticky error flag (bit 3 of 0x04) and ends the current buffer as if it had completed. Writing 1 to bit 3 of 0x04 clears the flag.
- R12: A buffer loaded with a count of 0 completes without any memory or peripheral access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | RAW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after reg_rd |
| irq | output | 1 | Channel interrupt |
| mem_req | output | 1 | Memory access request, held until mem_ack |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_ack | input | 1 | Memory access done |
| mem_err | input | 1 | Error response, valid with mem_ack |
| mem_rdata | input | 8 | Memory read byte, valid with mem_ack |
| per_req | input | 1 | Peripheral ready to give or take a byte |
| per_ack | output | 1 | One-cycle byte handover pulse |
| per_wdata | output | 8 | Byte to the peripheral |
| per_rdata | input | 8 | Byte from the peripheral |

## Verification
The main path is exercised in four ways:
- A single slot is loaded, to separate the stall and on transitions.
- Both slots are loaded before the peripheral is released, to show that next hands over to the second buffer in order.
- A base write is made while both slots are full, to show that it is dropped.
- A transfer runs in the reverse direction, to tell the memory-write path from the read path.

Further cases cover an error part-way through a buffer, which must end that buffer after one byte, and a zero-length buffer, which must make no access. A final run clears run in the middle of a buffer, which separates a graceful wind-down from an abort.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_STALL = 2'd1,
    CH_ON    = 2'd2,
    CH_NEXT  = 2'd3
  } ch_state_e;

  localparam int NSLOT = 2;
  localparam int BYTE_W = 8;

  // register offsets
  localparam int OFF_CTRL      = 'h00;
  localparam int OFF_CAUSE     = 'h04;
  localparam int OFF_PORT      = 'h08;
  localparam int OFF_STAT      = 'h0C;
  localparam int OFF_REMAIN    = 'h14;
  localparam int OFF_SLOT_CNT  = 'h20;
  localparam int OFF_SLOT_BASE = 'h24;
  localparam int SLOT_STRIDE   = 'h10;

  // control / cause bit positions
  localparam int B_STALL = 0;
  localparam int B_FREE  = 1;
  localparam int B_DIR   = 2;
  localparam int B_ERR   = 3;
  localparam int B_RUN   = 4;
  localparam int CTRL_W  = 5;
  localparam int PORT_W  = 4;
  localparam int STAT_LSB = 4;

endpackage

// File: rtl/pdma_regs.sv
module pdma_regs
  import pdma_pkg::*;
#(
  parameter int AW  = 32,
  parameter int CW  = 16,
  parameter int RAW = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       reg_wr,
  input  logic                       reg_rd,
  input  logic [RAW-1:0]             reg_addr,
  input  logic [31:0]                reg_wdata,
  output logic [31:0]                reg_rdata,
  input  ch_state_e                  state,
  input  logic [CW-1:0]              remaining,
  input  logic                       err_set,
  output logic [CTRL_W-1:0]          ctrl_o,
  output logic                       err_o,
  output logic [NSLOT-1:0][CW-1:0]   cnt_o,
  output logic [NSLOT-1:0][AW-1:0]   base_o,
  output logic                       load_o,
  output logic                       load_slot_o,
  output logic                       irq_o
);

  localparam logic [RAW-1:0] A_CTRL   = RAW'(OFF_CTRL);
  localparam logic [RAW-1:0] A_CAUSE  = RAW'(OFF_CAUSE);
  localparam logic [RAW-1:0] A_PORT   = RAW'(OFF_PORT);
  localparam logic [RAW-1:0] A_STAT   = RAW'(OFF_STAT);
  localparam logic [RAW-1:0] A_REMAIN = RAW'(OFF_REMAIN);

  logic [CTRL_W-1:0] ctrl_q;
  logic [PORT_W-1:0] port_q;
  logic              err_q;
  logic              irq_q;
  logic [31:0]       rd_d;
  logic [NSLOT-1:0]  hit_base;
  logic              stall_c, free_c;
  logic              unused_bits;

  assign unused_bits = ^reg_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      port_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == A_CTRL) ctrl_q <= reg_wdata[CTRL_W-1:0];
      if (reg_wr && reg_addr == A_PORT) port_q <= reg_wdata[PORT_W-1:0];
      if (err_set) err_q <= 1'b1;
      else if (reg_wr && reg_addr == A_CAUSE && reg_wdata[B_ERR]) err_q <= 1'b0;
    end
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    localparam logic [RAW-1:0] A_CNT  = RAW'(OFF_SLOT_CNT + s * SLOT_STRIDE);
    localparam logic [RAW-1:0] A_BASE = RAW'(OFF_SLOT_BASE + s * SLOT_STRIDE);
    logic [CW-1:0] c_q;
    logic [AW-1:0] b_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        c_q <= '0;
        b_q <= '0;
      end else begin
        if (reg_wr && reg_addr == A_CNT) c_q <= reg_wdata[CW-1:0];
        if (reg_wr && reg_addr == A_BASE && state != CH_NEXT) b_q <= reg_wdata[AW-1:0];
      end
    end
    assign hit_base[s] = reg_wr && (reg_addr == A_BASE);
    assign cnt_o[s]    = c_q;
    assign base_o[s]   = b_q;
  end

  assign load_o      = |hit_base;
  assign load_slot_o = hit_base[1];

  assign stall_c = (state == CH_STALL);
  assign free_c  = (state == CH_ON);

  always_comb begin
    rd_d = '0;
    if (reg_addr == A_CTRL)   rd_d = 32'(ctrl_q);
    if (reg_addr == A_CAUSE)  rd_d = 32'({err_q, 1'b0, free_c, stall_c});
    if (reg_addr == A_PORT)   rd_d = 32'(port_q);
    if (reg_addr == A_STAT)   rd_d = 32'(state) << STAT_LSB;
    if (reg_addr == A_REMAIN) rd_d = 32'(remaining);
    for (int s = 0; s < NSLOT; s++) begin
      if (reg_addr == RAW'(OFF_SLOT_CNT + s * SLOT_STRIDE))  rd_d = 32'(cnt_o[s]);
      if (reg_addr == RAW'(OFF_SLOT_BASE + s * SLOT_STRIDE)) rd_d = 32'(base_o[s]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq_q     <= 1'b0;
    end else begin
      if (reg_rd) reg_rdata <= rd_d;
      irq_q <= (stall_c & ctrl_q[B_STALL]) | (free_c & ctrl_q[B_FREE]) |
               (err_q & ctrl_q[B_ERR]);
    end
  end

  assign ctrl_o = ctrl_q;
  assign err_o  = err_q;
  assign irq_o  = irq_q;

endmodule

// File: rtl/pdma_fsm.sv
module pdma_fsm
  import pdma_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      run,
  input  logic      load,
  input  logic      load_slot,
  input  logic      done,
  output ch_state_e state_o,
  output logic      start_o,
  output logic      start_slot_o
);

  ch_state_e st_q, st_d;
  logic      go, go_slot, pend_q, pend_d, start_q, slot_q;

  always_comb begin
    st_d    = st_q;
    go      = 1'b0;
    go_slot = pend_q;
    pend_d  = pend_q;
    case (st_q)
      CH_IDLE:  if (run) st_d = CH_STALL;
      CH_STALL: begin
        if (!run) st_d = CH_IDLE;
        else if (load) begin
          st_d    = CH_ON;
          go      = 1'b1;
          go_slot = load_slot;
        end
      end
      CH_ON: begin
        if (done && load && run) begin
          go      = 1'b1;
          go_slot = load_slot;
        end else if (done) begin
          st_d = CH_STALL;
        end else if (load && run) begin
          st_d   = CH_NEXT;
          pend_d = load_slot;
        end
      end
      CH_NEXT: begin
        if (done) begin
          st_d    = CH_ON;
          go      = 1'b1;
          go_slot = pend_q;
        end
      end
      default: st_d = CH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= CH_IDLE;
      pend_q  <= 1'b0;
      start_q <= 1'b0;
      slot_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      pend_q  <= pend_d;
      start_q <= go;
      slot_q  <= go_slot;
    end
  end

  assign state_o      = st_q;
  assign start_o      = start_q;
  assign start_slot_o = slot_q;

endmodule

// File: rtl/pdma_mover.sv
module pdma_mover
  import pdma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CW-1:0]     cnt_init,
  input  logic [AW-1:0]     base_init,
  input  logic              dir_rx,
  output logic              done_o,
  output logic              err_o,
  output logic [CW-1:0]     remaining_o,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [BYTE_W-1:0] mem_rdata,
  input  logic              per_req,
  output logic              per_ack,
  output logic [BYTE_W-1:0] per_wdata,
  input  logic [BYTE_W-1:0] per_rdata
);

  typedef enum logic [1:0] {MV_WAIT, MV_MEM, MV_PER} mv_e;

  mv_e           mv;
  logic          busy, rx;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      mv        <= MV_WAIT;
      busy      <= 1'b0;
      rx        <= 1'b0;
      cnt       <= '0;
      addr      <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
      per_ack   <= 1'b0;
      per_wdata <= '0;
      done_o    <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      per_ack <= 1'b0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        cnt  <= cnt_init;
        addr <= base_init;
        rx   <= dir_rx;
        mv   <= MV_WAIT;
      end else begin
        case (mv)
          MV_WAIT: begin
            if (busy) begin
              if (cnt == '0) begin
                busy   <= 1'b0;
                done_o <= 1'b1;
              end else if (per_req) begin
                mem_req <= 1'b1;
                mem_we  <= rx;
                mv      <= MV_MEM;
                if (rx) begin
                  mem_wdata <= per_rdata;
                  per_ack   <= 1'b1;
                end
              end
            end
          end
          MV_MEM: begin
            if (mem_ack) begin
              mem_req <= 1'b0;
              if (mem_err) begin
                busy   <= 1'b0;
                done_o <= 1'b1;
                err_o  <= 1'b1;
                mv     <= MV_WAIT;
              end else if (rx) begin
                cnt  <= cnt - 1'b1;
                addr <= addr + 1'b1;
                mv   <= MV_WAIT;
              end else begin
                per_wdata <= mem_rdata;
                per_ack   <= 1'b1;
                mv        <= MV_PER;
              end
            end
          end
          MV_PER: begin
            cnt  <= cnt - 1'b1;
            addr <= addr + 1'b1;
            mv   <= MV_WAIT;
          end
          default: mv <= MV_WAIT;
        endcase
      end
    end
  end

  assign mem_addr    = addr;
  assign remaining_o = cnt;

endmodule

// File: rtl/pdma_chan.sv
module pdma_chan
  import pdma_pkg::*;
#(
  parameter int AW  = 32,
  parameter int CW  = 16,
  parameter int RAW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_wr,
  input  logic           reg_rd,
  input  logic [RAW-1:0] reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  output logic           irq,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [7:0]     mem_wdata,
  input  logic           mem_ack,
  input  logic           mem_err,
  input  logic [7:0]     mem_rdata,
  input  logic           per_req,
  output logic           per_ack,
  output logic [7:0]     per_wdata,
  input  logic [7:0]     per_rdata
);

  ch_state_e                 st;
  logic [CTRL_W-1:0]         ctrl_q;
  logic                      err_q;
  logic [NSLOT-1:0][CW-1:0]  slot_cnt;
  logic [NSLOT-1:0][AW-1:0]  slot_base;
  logic                      load_p, load_slot;
  logic                      start_p, start_slot;
  logic                      done_p, err_p;
  logic [CW-1:0]             remaining;

  pdma_regs #(.AW(AW), .CW(CW), .RAW(RAW)) u_regs (
    .clk(clk), .rst(rst),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .state(st), .remaining(remaining), .err_set(err_p),
    .ctrl_o(ctrl_q), .err_o(err_q), .cnt_o(slot_cnt), .base_o(slot_base),
    .load_o(load_p), .load_slot_o(load_slot), .irq_o(irq)
  );

  pdma_fsm u_fsm (
    .clk(clk), .rst(rst),
    .run(ctrl_q[B_RUN]), .load(load_p), .load_slot(load_slot), .done(done_p),
    .state_o(st), .start_o(start_p), .start_slot_o(start_slot)
  );

  pdma_mover #(.AW(AW), .CW(CW)) u_mover (
    .clk(clk), .rst(rst),
    .start(start_p), .cnt_init(slot_cnt[start_slot]),
    .base_init(slot_base[start_slot]), .dir_rx(ctrl_q[B_DIR]),
    .done_o(done_p), .err_o(err_p), .remaining_o(remaining),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err),
    .mem_rdata(mem_rdata), .per_req(per_req), .per_ack(per_ack),
    .per_wdata(per_wdata), .per_rdata(per_rdata)
  );

endmodule

// File: rtl/pdma_chan_chk.sv
module pdma_chan_chk
  import pdma_pkg::*;
#(
  parameter int AW = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        st,
  input logic              load,
  input logic              done,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [AW-1:0]     mem_addr,
  input logic              per_ack,
  input logic              irq,
  input logic [CTRL_W-1:0] ctrl,
  input logic              err
);

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  assert_ack_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    per_ack |=> !per_ack);

  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (st == CH_IDLE) |-> !mem_req);

  assert_next_entry_R4: assert property (@(posedge clk) disable iff (rst)
    (st == CH_NEXT && $past(st) != CH_NEXT) |-> ($past(st) == CH_ON && $past(load)));

  assert_next_exit_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(st) == CH_NEXT && st != CH_NEXT) |-> (st == CH_ON && $past(done)));

  assert_stall_entry_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(st) == CH_ON && st == CH_STALL) |-> $past(done));

  assert_idle_entry_R10: assert property (@(posedge clk) disable iff (rst)
    (st == CH_IDLE && $past(st) != CH_IDLE) |-> ($past(st) == CH_STALL));

  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (rst)
    $past(!(st == CH_STALL && ctrl[B_STALL]) && !(st == CH_ON && ctrl[B_FREE]) &&
          !(err && ctrl[B_ERR])) |-> !irq);

endmodule

bind pdma_chan pdma_chan_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .st(st), .load(load_p), .done(done_p),
  .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .per_ack(per_ack), .irq(irq), .ctrl(ctrl_q), .err(err_q)
);

// File: tb/sim_pdma_chan.sv
`timescale 1ns/1ps
module sim_pdma_chan;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_ack, mem_err;
  logic [7:0]  mem_rdata;
  logic        per_req = 1'b0;
  logic        per_ack;
  logic [7:0]  per_wdata, per_rdata;

  always #2.5 clk = ~clk;

  pdma_chan u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .per_req(per_req), .per_ack(per_ack), .per_wdata(per_wdata), .per_rdata(per_rdata)
  );

  // memory and peripheral models
  logic [7:0] mem [0:255];
  logic [7:0] txlog [0:63];
  int txn, rxn, nacc;
  logic       rx_mode = 1'b0;
  logic       err_on = 1'b0;
  logic [7:0] err_addr = 8'h00;
  int ntests = 0, nfail = 0;
  logic [31:0] rval;

  function automatic logic [7:0] pat(int a);
    return 8'((a * 3 + 7) & 8'hFF);
  endfunction

  function automatic logic [7:0] rxsrc(int i);
    return 8'(8'hC0 + i);
  endfunction

  assign per_rdata = rxsrc(rxn);

  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0; mem_err <= 1'b0; mem_rdata <= '0;
      txn <= 0; rxn <= 0; nacc <= 0;
      for (int i = 0; i < 256; i++) mem[i] <= pat(i);
    end else begin
      mem_ack <= mem_req && !mem_ack;
      mem_err <= mem_req && !mem_ack && err_on && (mem_addr[7:0] == err_addr);
      if (mem_req && !mem_ack) begin
        mem_rdata <= mem[mem_addr[7:0]];
        if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        nacc <= nacc + 1;
      end
      if (per_ack) begin
        if (rx_mode) rxn <= rxn + 1;
        else begin txlog[txn[5:0]] <= per_wdata; txn <= txn + 1; end
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; rval = reg_rdata;
  endtask

  task automatic wait_state(logic [1:0] s, string tag);
    int n = 0;
    rd(8'h0C);
    while (rval[5:4] != s && n < 500) begin rd(8'h0C); n++; end
    chk(tag, 32'(rval[5:4]), 32'(s));
  endtask

  task automatic t_reset();
    chk("R1 reset state", 32'(u0.reg_rdata), 32'h0);
    rd(8'h0C); chk("R1 status idle", rval, 32'h0);
    chk("R1 irq low", 32'(irq), 32'h0);
    chk("R1 mem_req low", 32'(mem_req), 32'h0);
  endtask

  task automatic t_regs();
    wr(8'h00, 32'h0B); rd(8'h00); chk("R2 ctrl readback", rval, 32'h0B);
    wr(8'h08, 32'h5);  rd(8'h08); chk("R2 port readback", rval, 32'h5);
    wr(8'h30, 32'h1234); rd(8'h30); chk("R2 slot1 count", rval, 32'h1234);
    wr(8'h20, 32'h1); wr(8'h24, 32'h40);
    repeat (10) @(negedge clk);
    chk("R3 no access while stopped", 32'(nacc), 32'h0);
    rd(8'h0C); chk("R3 stays idle", rval, 32'h0);
    rd(8'h24); chk("R2 slot0 base stored", rval, 32'h40);
  endtask

  task automatic t_run();
    wr(8'h00, 32'h10);
    wait_state(2'd1, "R3 run enters stall");
    repeat (3) @(negedge clk);
    chk("R9 stall masked", 32'(irq), 32'h0);
    wr(8'h00, 32'h11); repeat (2) @(negedge clk);
    chk("R9 stall unmasked", 32'(irq), 32'h1);
  endtask

  task automatic t_double();
    int t0, left;
    wr(8'h00, 32'h12);
    per_req = 1'b0;
    wr(8'h20, 32'd4); wr(8'h24, 32'h40);
    rd(8'h0C); chk("R4 stall to on", 32'(rval[5:4]), 32'd2);
    rd(8'h14); chk("R5 remaining loaded", rval, 32'd4);
    chk("R9 free-slot irq", 32'(irq), 32'h1);
    wr(8'h30, 32'd3); wr(8'h34, 32'h50);
    rd(8'h0C); chk("R4 on to next", 32'(rval[5:4]), 32'd3);
    chk("R9 no irq in next", 32'(irq), 32'h0);
    wr(8'h24, 32'h99);
    rd(8'h0C); chk("R4 write in next ignored", 32'(rval[5:4]), 32'd3);
    rd(8'h24); chk("R4 base kept", rval, 32'h40);
    per_req = 1'b1;
    while (txn < 4) @(negedge clk);
    per_req = 1'b0;
    repeat (20) @(negedge clk);
    rd(8'h0C); chk("R7 next to on", 32'(rval[5:4]), 32'd2);
    chk("R7 free-slot cause irq", 32'(irq), 32'h1);
    left = 3 - (txn - 4);
    rd(8'h14); chk("R5 remaining per byte", rval, 32'(left));
    for (int i = 0; i < 4; i++) chk("R5 tx byte order", 32'(txlog[i]), 32'(pat(8'h40 + i)));
    per_req = 1'b1;
    wait_state(2'd1, "R8 on to stall");
    chk("R7 total bytes", 32'(txn), 32'd7);
    for (int i = 0; i < 3; i++) chk("R7 second buffer bytes", 32'(txlog[4 + i]), 32'(pat(8'h50 + i)));
    rd(8'h14); chk("R8 remaining zero", rval, 32'h0);
    rd(8'h04); chk("R8 stall cause", rval, 32'h1);
    chk("R9 stall masked in stall", 32'(irq), 32'h0);
    t0 = txn;
  endtask

  task automatic t_rx();
    rx_mode = 1'b1;
    wr(8'h00, 32'h14);
    wr(8'h20, 32'd3); wr(8'h24, 32'h80);
    wait_state(2'd1, "R6 rx completes");
    for (int i = 0; i < 3; i++) chk("R6 rx memory", 32'(mem[8'h80 + i]), 32'(rxsrc(i)));
    chk("R6 rx byte count", 32'(rxn), 32'd3);
    rx_mode = 1'b0;
  endtask

  task automatic t_err();
    int t0 = txn;
    err_addr = 8'h61; err_on = 1'b1;
    wr(8'h00, 32'h18);
    wr(8'h30, 32'd4); wr(8'h34, 32'h60);
    wait_state(2'd1, "R11 error ends buffer");
    chk("R11 one byte before error", 32'(txn - t0), 32'd1);
    rd(8'h04); chk("R11 error flag", rval, 32'h9);
    chk("R11 error irq", 32'(irq), 32'h1);
    wr(8'h04, 32'h08);
    rd(8'h04); chk("R11 error cleared", rval, 32'h1);
    @(negedge clk);
    chk("R11 irq after clear", 32'(irq), 32'h0);
    err_on = 1'b0;
  endtask

  task automatic t_zero();
    int a0 = nacc, t0 = txn;
    wr(8'h20, 32'd0); wr(8'h24, 32'h70);
    wait_state(2'd1, "R12 zero count completes");
    repeat (5) @(negedge clk);
    chk("R12 no memory access", 32'(nacc), 32'(a0));
    chk("R12 no peripheral byte", 32'(txn), 32'(t0));
  endtask

  task automatic t_stop();
    int t0 = txn;
    per_req = 1'b0;
    wr(8'h00, 32'h10);
    wr(8'h20, 32'd2); wr(8'h24, 32'h40);
    wr(8'h00, 32'h00);
    repeat (5) @(negedge clk);
    rd(8'h0C); chk("R10 buffer not aborted", 32'(rval[5:4]), 32'd2);
    per_req = 1'b1;
    wait_state(2'd0, "R10 idle after finish");
    chk("R10 bytes finished", 32'(txn - t0), 32'd2);
    chk("R10 last byte", 32'(txlog[t0 + 1]), 32'(pat(8'h41)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++; ntests++;
    $display("FAIL watchdog R1-scope run hung act=0 exp=1");
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_run();
    t_double();
    t_rx();
    t_err();
    t_zero();
    t_stop();
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

endmodule